// File: doc/BRIEF.md
# Host-Controller Byte Mailbox

This block is a small two-port register file that lets a host processor and a management controller exchange single bytes and signal each other. It holds an inbound byte (host to controller), an outbound byte (controller to host) and one shared status byte. Hardware keeps a full flag for each direction. Each full flag sets when its writer stores a byte and clears when its reader fetches it. Each side receives an interrupt while the other side has left something for it to read.

The status byte combines two kinds of bits. Some are owned by controller software: bit 7 means the controller is alive, bit 6 means the channel is open and a version has been agreed, and bits 5, 4 and 2 are spare. The rest are flags that hardware keeps up to date. When the controller rewrites the status byte, the host is interrupted. This lets the controller announce state changes without a data transfer. Both ports use single-cycle read and write strobes with a one-bit address in a single clock domain. Read data appears in a register one cycle after the strobe.

Host address 0 is the data location and host address 1 is the command/status location. Controller address 0 is the data location and controller address 1 is the status location.

Top module: `hbm_mailbox`

## Requirements
- R1: After reset, both full flags, the command/data bit, all software status bits, both interrupts and both read-data registers are zero.
- R2: A host write at address 0 stores the byte in the inbound buffer. It sets the inbound-full flag (status bit 1), clears the command/data flag (status bit 3) and raises `ctl_irq` from the next cycle.
- R3: A host write at address 1 does the same as R2, except that status bit 3 becomes 1. Bit 3 keeps its value until the next host write.
- R4: A controller read at address 0 returns the inbound byte on `ctl_rdata` one cycle later. It clears the inbound-full flag and drops `ctl_irq`, unless a host write arrives in the same cycle.
- R5: A controller write at address 0 stores the outbound byte, sets the outbound-full flag (status bit 0) and raises `host_irq` from the next cycle.
- R6: A host read at address 0 returns the outbound byte on `host_rdata` one cycle later and clears the outbound-full flag. `host_irq` drops unless a status-change interrupt is still pending.
- R7: A controller write at address 1 updates only status bits 7, 6, 5, 4 and 2. Bits 3, 1 and 0 keep their hardware values. The write also raises a pending status-change interrupt on `host_irq`.
- R8: A host read at address 1 returns the whole status byte. A controller read at address 1 also returns it. The host read clears the pending status-change interrupt, but `host_irq` stays high while the outbound-full flag is set.
- R9: When a write and a read of the same buffer fall in the same cycle, the read returns the old byte and the full flag stays set.
- R10: A second write to a buffer that is already full replaces the byte, and the later value is the one read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Host location: 0 data, 1 command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| host_irq | output | 1 | Interrupt to the host |
| ctl_wr | input | 1 | Controller write strobe |
| ctl_rd | input | 1 | Controller read strobe |
| ctl_addr | input | 1 | Controller location: 0 data, 1 status |
| ctl_wdata | input | 8 | Controller write byte |
| ctl_rdata | output | 8 | Controller read byte, registered |
| ctl_irq | output | 1 | Interrupt to the controller |

## Verification
The hardest case to reach is a cycle in which both ports act on the same buffer at once, for example a host write landing while the controller drains the inbound byte. Ordinary use spreads such accesses over many cycles. The bench fills a buffer first and then asserts the opposing strobes in one shared cycle. Another hard case is `host_irq` with two causes, outbound-full and a pending status change. To reach it, the bench arranges a status write and an outbound write before the host reads, so each clearing read removes only one cause.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_OBF  = 0;
  localparam int BIT_IBF  = 1;
  localparam int BIT_CD   = 3;
  localparam logic [STAT_W-1:0] SW_MASK = 8'hF4;
endpackage

// File: rtl/mbx_buf.sv
module mbx_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         rd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data,
  output logic         full
);
  logic [W-1:0] data_d;
  logic         full_d;

  always_comb begin
    data_d = data;
    full_d = full;
    if (wr) begin
      data_d = wdata;
      full_d = 1'b1;
    end else if (rd) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else begin
      if (wr) data <= data_d;
      full <= full_d;
    end
  end

  a_r2_wr_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> full);
  a_r4_rd_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !full);
  a_r10_hold_without_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(data));
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [STAT_W-1:0] sw_wdata,
  input  logic              host_wr,
  input  logic              host_cd,
  input  logic              ack,
  output logic [STAT_W-1:0] sw_bits,
  output logic              cd,
  output logic              pend
);
  logic [STAT_W-1:0] sw_bits_d;
  logic              cd_d;
  logic              pend_d;

  always_comb begin
    sw_bits_d = sw_wr ? (sw_wdata & SW_MASK) : sw_bits;
    cd_d      = host_wr ? host_cd : cd;
    pend_d    = pend;
    if (sw_wr)    pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_bits <= '0;
      cd      <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (sw_wr)   sw_bits <= sw_bits_d;
      if (host_wr) cd      <= cd_d;
      pend <= pend_d;
    end
  end

  a_r7_sw_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> $stable(sw_bits));
  a_r7_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> pend);
  a_r3_cd_tracks_host: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (cd == $past(host_cd)));
endmodule

// File: rtl/hbm_mailbox.sv
module hbm_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic              ctl_addr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic              ctl_irq
);
  localparam int RD_W = (DATA_W > STAT_W) ? DATA_W : STAT_W;

  logic [DATA_W-1:0] in_data, out_data;
  logic              in_full, out_full;
  logic [STAT_W-1:0] sw_bits, status;
  logic              cd, pend;
  logic [DATA_W-1:0] host_rdata_d, ctl_rdata_d;
  logic [RD_W-1:0]   status_ext;

  mbx_buf #(.W(DATA_W)) u_inbound (
    .clk(clk), .rst_n(rst_n),
    .wr(host_wr), .rd(ctl_rd && !ctl_addr),
    .wdata(host_wdata), .data(in_data), .full(in_full)
  );

  mbx_buf #(.W(DATA_W)) u_outbound (
    .clk(clk), .rst_n(rst_n),
    .wr(ctl_wr && !ctl_addr), .rd(host_rd && !host_addr),
    .wdata(ctl_wdata), .data(out_data), .full(out_full)
  );

  mbx_status u_status (
    .clk(clk), .rst_n(rst_n),
    .sw_wr(ctl_wr && ctl_addr), .sw_wdata(ctl_wdata[STAT_W-1:0]),
    .host_wr(host_wr), .host_cd(host_addr),
    .ack(host_rd && host_addr),
    .sw_bits(sw_bits), .cd(cd), .pend(pend)
  );

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (SW_MASK[i]) begin : g_sw
      assign status[i] = sw_bits[i];
    end else if (i == BIT_OBF) begin : g_obf
      assign status[i] = out_full;
    end else if (i == BIT_IBF) begin : g_ibf
      assign status[i] = in_full;
    end else if (i == BIT_CD) begin : g_cd
      assign status[i] = cd;
    end else begin : g_zero
      assign status[i] = 1'b0;
    end
  end

  assign status_ext = RD_W'(status);

  always_comb begin
    host_rdata_d = host_rdata;
    ctl_rdata_d  = ctl_rdata;
    if (host_rd) host_rdata_d = host_addr ? status_ext[DATA_W-1:0] : out_data;
    if (ctl_rd)  ctl_rdata_d  = ctl_addr  ? status_ext[DATA_W-1:0] : in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      ctl_rdata  <= '0;
    end else begin
      if (host_rd) host_rdata <= host_rdata_d;
      if (ctl_rd)  ctl_rdata  <= ctl_rdata_d;
    end
  end

  assign host_irq = out_full | pend;
  assign ctl_irq  = in_full;

  a_r5_out_write_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_addr) |=> host_irq);
  a_r6_out_read_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_addr && !ctl_wr && !pend) |=> !host_irq);
  a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr && !out_full && !ctl_wr) |=> !host_irq);
  a_r2_in_write_irq: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> ctl_irq);
endmodule

// File: tb/hbm_mailbox_tb_top.sv
module hbm_mailbox_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic ctl_wr = 0, ctl_rd = 0, ctl_addr = 0;
  logic [7:0] ctl_wdata = 0;
  logic [7:0] host_rdata, ctl_rdata;
  logic host_irq, ctl_irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  hbm_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_irq(ctl_irq)
  );

  // ops: 0 host wr data, 1 host wr cmd, 2 ctl rd data, 3 ctl wr data,
  //      4 host rd data, 5 ctl wr status, 6 host rd status, 7 ctl rd status
  // entry: {op[2:0], wdata[7:0], exp_rd[7:0], exp_ctl_irq, exp_host_irq}
  localparam int NV = 19;
  localparam logic [20:0] VEC [NV] = '{
    {3'd7, 8'h00, 8'h00, 1'b0, 1'b0},  // R1 status zero
    {3'd0, 8'h5A, 8'h00, 1'b1, 1'b0},  // R2
    {3'd7, 8'h00, 8'h02, 1'b1, 1'b0},  // R2 IBF, cd=0
    {3'd2, 8'h00, 8'h5A, 1'b0, 1'b0},  // R4
    {3'd1, 8'h01, 8'h00, 1'b1, 1'b0},  // R3
    {3'd7, 8'h00, 8'h0A, 1'b1, 1'b0},  // R3 cd=1
    {3'd2, 8'h00, 8'h01, 1'b0, 1'b0},  // R4
    {3'd7, 8'h00, 8'h08, 1'b0, 1'b0},  // R3 cd kept
    {3'd3, 8'hC3, 8'h00, 1'b0, 1'b1},  // R5
    {3'd7, 8'h00, 8'h09, 1'b0, 1'b1},  // R5 OBF
    {3'd4, 8'h00, 8'hC3, 1'b0, 1'b0},  // R6
    {3'd5, 8'hFF, 8'h00, 1'b0, 1'b1},  // R7
    {3'd6, 8'h00, 8'hFC, 1'b0, 1'b0},  // R8
    {3'd5, 8'h0B, 8'h00, 1'b0, 1'b1},  // R7 hw bits untouched
    {3'd3, 8'h77, 8'h00, 1'b0, 1'b1},  // R5
    {3'd6, 8'h00, 8'h09, 1'b0, 1'b1},  // R8 irq stays with OBF
    {3'd4, 8'h00, 8'h77, 1'b0, 1'b0},  // R6
    {3'd5, 8'hC0, 8'h00, 1'b0, 1'b1},  // R7
    {3'd6, 8'h00, 8'hC8, 1'b0, 1'b0}   // R8
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [7:0] wd);
    @(negedge clk);
    host_wr = (op == 0) || (op == 1);
    host_rd = (op == 4) || (op == 6);
    host_addr = (op == 1) || (op == 6);
    host_wdata = wd;
    ctl_wr = (op == 3) || (op == 5);
    ctl_rd = (op == 2) || (op == 7);
    ctl_addr = (op == 5) || (op == 7);
    ctl_wdata = wd;
    @(negedge clk);
    host_wr = 0; host_rd = 0; ctl_wr = 0; ctl_rd = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [20:0] v;
    repeat (3) @(negedge clk);
    check("R1 host_irq", {7'd0, host_irq}, 8'h00);
    check("R1 ctl_irq", {7'd0, ctl_irq}, 8'h00);
    check("R1 host_rdata", host_rdata, 8'h00);
    check("R1 ctl_rdata", ctl_rdata, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      do_op(v[20:18], v[17:10]);
      if (v[20:18] == 3'd2 || v[20:18] == 3'd7)
        check($sformatf("vec%0d ctl_rdata", i), ctl_rdata, v[9:2]);
      if (v[20:18] == 3'd4 || v[20:18] == 3'd6)
        check($sformatf("vec%0d host_rdata", i), host_rdata, v[9:2]);
      check($sformatf("vec%0d ctl_irq", i), {7'd0, ctl_irq}, {7'd0, v[1]});
      check($sformatf("vec%0d host_irq", i), {7'd0, host_irq}, {7'd0, v[0]});
    end

    // R10 overwrite while full
    do_op(3'd0, 8'h11);
    do_op(3'd0, 8'h22);
    do_op(3'd2, 8'h00);
    check("R10 latest inbound byte", ctl_rdata, 8'h22);

    // R9 inbound: host write and ctl read in one cycle
    do_op(3'd0, 8'h33);
    @(negedge clk);
    host_wr = 1; host_addr = 0; host_wdata = 8'h44;
    ctl_rd = 1; ctl_addr = 0;
    @(negedge clk);
    host_wr = 0; ctl_rd = 0;
    check("R9 ctl read returns old byte", ctl_rdata, 8'h33);
    check("R9 ctl_irq stays", {7'd0, ctl_irq}, 8'h01);
    do_op(3'd2, 8'h00);
    check("R9 new byte kept", ctl_rdata, 8'h44);

    // R9 outbound: ctl write and host read in one cycle
    do_op(3'd3, 8'h55);
    @(negedge clk);
    ctl_wr = 1; ctl_addr = 0; ctl_wdata = 8'h66;
    host_rd = 1; host_addr = 0;
    @(negedge clk);
    ctl_wr = 0; host_rd = 0;
    check("R9 host read returns old byte", host_rdata, 8'h55);
    check("R9 host_irq stays", {7'd0, host_irq}, 8'h01);
    do_op(3'd4, 8'h00);
    check("R9 outbound new byte", host_rdata, 8'h66);
    check("R6 host_irq low", {7'd0, host_irq}, 8'h00);

    // R1 reset from a busy state
    do_op(3'd0, 8'h99);
    do_op(3'd5, 8'hC4);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 irqs after reset", {6'd0, host_irq, ctl_irq}, 8'h00);
    check("R1 ctl_rdata after reset", ctl_rdata, 8'h00);
    rst_n = 1'b1;
    do_op(3'd7, 8'h00);
    check("R1 status after reset", ctl_rdata, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule